// File: doc/BRIEF.md
# Lockable-Update Pulse Width Modulator

This block is a single-channel pulse width modulator driven by a small memory-mapped register port. Software sets a period and a duty length, both counted in clock ticks, and picks a level for the active part of each period and a level for the rest of it. The output is left-aligned and free-running: each period starts at the active level for `duty` ticks, then holds the idle level until the period ends.

Period and duty writes land in holding registers. The running counter only takes them at a period boundary, so no period is ever cut short or stretched by a write. A lock bit in the control register holds the waveform as it is while software rewrites several values. Clearing the lock releases the held values. The polarity bits written in that same control write go with them, so all of them take effect together at the next boundary.

Top module: `pwm_locked_timer`

## Requirements
- R1: After reset every register reads 0 and `pwm_out` is 0.
- R2: Byte addresses decode as 0x0 live counter (read-only; writes ignored), 0x4 period holding register, 0x8 duty holding register, 0xC control. Period and duty read back the last written value on the cycle after the write.
- R3: Control bit 0 enables and bit 1 selects continuous operation; the channel runs only with both set. Bit 3 is the active level and bit 4 the idle level (1 = high). Bit 6 is the lock. Every other bit, including bit 5 (alignment) and bit 8 (low power), reads 0 and ignores writes.
- R4: While running, the counter advances by one each clock from 0 to period−1 and then returns to 0.
- R5: While running, `pwm_out` shows the active level when the count is below duty and the idle level otherwise. Duty 0 gives a constant idle level. Duty ≥ period gives a constant active level.
- R6: While not running, the counter is 0 one cycle after the stop and `pwm_out` equals control bit 4.
- R7: The control write that starts the channel loads the holding period and duty and that write's polarity bits at once. The first running cycle shows count 0.
- R8: With the lock clear, period, duty and polarity changes written during a period take effect only at the next period boundary.
- R9: With the lock set, period and duty writes are captured and read back, but the waveform keeps its old period, duty and polarity across any number of boundaries.
- R10: After the control write that clears the lock, the captured period and duty and that write's polarity bits take effect together at the next period boundary.
- R11: A period of 0 holds the counter at 0 while running. The output is then constantly active if duty is non-zero and constantly idle otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| pwm_out | output | 1 | Modulated output |

## Verification
The waveform is swept over every period from 0 to 5, every duty from 0 to 6, and both polarity choices. This separates the duty-0, partial-duty and duty-at-or-above-period regimes and exposes off-by-one errors in the wrap and in the compare. Mid-period writes with the lock clear show whether updates wait for the boundary. Writes made under lock, followed by an unlock that also flips polarity, show whether captured values leak early and whether all three change on the same boundary. Stop and restart sequences show the idle level, the cleared counter and the immediate load on start.

// File: rtl/pwm_locked_timer.sv
module pwm_locked_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);

  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(4'hC);
  localparam int B_EN = 0, B_CONT = 1, B_ACT = 3, B_IDLE = 4, B_LOCK = 6;
  localparam logic [DATA_W-1:0] CTL_MASK = DATA_W'(32'h5B);

  logic [DATA_W-1:0] hold_per, hold_duty, ctl;
  logic [DATA_W-1:0] per_d, duty_d, ctl_d;
  logic [DATA_W-1:0] act_per, act_duty, cnt;
  logic              act_hi, idle_hi;
  logic              run, last;

  assign per_d  = (bus_we && bus_addr == A_PER)  ? bus_wdata : hold_per;
  assign duty_d = (bus_we && bus_addr == A_DUTY) ? bus_wdata : hold_duty;
  assign ctl_d  = (bus_we && bus_addr == A_CTL)  ? (bus_wdata & CTL_MASK) : ctl;

  assign run  = ctl[B_EN] & ctl[B_CONT];
  assign last = ({1'b0, cnt} + (DATA_W+1)'(1)) >= {1'b0, act_per};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_per  <= '0;
      hold_duty <= '0;
      ctl       <= '0;
      act_per   <= '0;
      act_duty  <= '0;
      act_hi    <= 1'b0;
      idle_hi   <= 1'b0;
      cnt       <= '0;
    end else begin
      hold_per  <= per_d;
      hold_duty <= duty_d;
      ctl       <= ctl_d;
      if (!run) begin
        cnt      <= '0;
        act_per  <= per_d;
        act_duty <= duty_d;
        act_hi   <= ctl_d[B_ACT];
        idle_hi  <= ctl_d[B_IDLE];
      end else if (last) begin
        cnt <= '0;
        if (!ctl[B_LOCK]) begin
          act_per  <= hold_per;
          act_duty <= hold_duty;
          act_hi   <= ctl[B_ACT];
          idle_hi  <= ctl[B_IDLE];
        end
      end else begin
        cnt <= cnt + DATA_W'(1);
      end
    end
  end

  assign pwm_out = run ? ((cnt < act_duty) ? act_hi : idle_hi) : ctl[B_IDLE];

  always_comb begin
    unique case (bus_addr)
      A_CNT:   bus_rdata = cnt;
      A_PER:   bus_rdata = hold_per;
      A_DUTY:  bus_rdata = hold_duty;
      A_CTL:   bus_rdata = ctl;
      default: bus_rdata = '0;
    endcase
  end

  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_per != '0) |-> cnt < act_per);

  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  p_locked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctl[B_LOCK]) |=> ($stable(act_per) && $stable(act_duty) &&
                              $stable(act_hi) && $stable(idle_hi)));

  p_no_mid_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> ($stable(act_per) && $stable(act_duty) &&
                        $stable(act_hi) && $stable(idle_hi)));

  p_period_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_per == '0) |=> cnt == '0);

endmodule

// File: tb/test_pwm_locked_timer.sv
`timescale 1ns/1ps
module test_pwm_locked_timer;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        pwm_out;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_per = 0, m_duty = 0, m_ctl = 0;
  logic [31:0] s_per = 0, s_duty = 0, ph = 0;
  logic        s_act = 0, s_idle = 0;

  pwm_locked_timer i_pwm_locked_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d, input string tag);
    logic [31:0] n_per, n_duty, n_ctl;
    logic orun, nrun, exp_o;
    bus_we = we; bus_addr = a; bus_wdata = d;
    n_per  = (we && a == 4'h4) ? d : m_per;
    n_duty = (we && a == 4'h8) ? d : m_duty;
    n_ctl  = (we && a == 4'hC) ? (d & 32'h5B) : m_ctl;
    orun = m_ctl[0] & m_ctl[1];
    if (!orun) begin
      ph = 0; s_per = n_per; s_duty = n_duty; s_act = n_ctl[3]; s_idle = n_ctl[4];
    end else if (64'(ph) + 1 >= 64'(s_per)) begin
      ph = 0;
      if (!m_ctl[6]) begin
        s_per = m_per; s_duty = m_duty; s_act = m_ctl[3]; s_idle = m_ctl[4];
      end
    end else ph = ph + 1;
    m_per = n_per; m_duty = n_duty; m_ctl = n_ctl;
    @(posedge clk); @(negedge clk);
    bus_we = 0; bus_addr = 4'h0;
    nrun = m_ctl[0] & m_ctl[1];
    exp_o = nrun ? ((ph < s_duty) ? s_act : s_idle) : m_ctl[4];
    #0.5;
    check({tag, " out"}, 32'(pwm_out), 32'(exp_o));
    check({tag, " count"}, bus_rdata, ph);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 4'h0, 0, tag);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; #0.5;
    check(tag, bus_rdata, exp);
    bus_addr = 4'h0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    #1;
    check("R1 out in reset", 32'(pwm_out), 0);
    rd(4'h0, 0, "R1 counter"); rd(4'h4, 0, "R1 period");
    rd(4'h8, 0, "R1 duty");    rd(4'hC, 0, "R1 control");
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    cyc(1, 4'h4, 32'h1234_5678, "R2 period write");
    rd(4'h4, 32'h1234_5678, "R2 period readback");
    cyc(1, 4'h8, 32'h0BAD_F00D, "R2 duty write");
    rd(4'h8, 32'h0BAD_F00D, "R2 duty readback");
    cyc(1, 4'h0, 32'h0000_0055, "R2 counter write ignored");
    cyc(1, 4'hC, 32'hFFFF_FFA4, "R3 reserved bits");
    rd(4'hC, 32'h0, "R3 reserved bits read zero");
    cyc(1, 4'hC, 32'h0000_0011, "R3 enable without continuous");
    rd(4'hC, 32'h11, "R3 control readback");
    idle(3, "R6 idle high while stopped");
    cyc(1, 4'hC, 32'h0000_0002, "R3 continuous without enable");
    idle(2, "R6 idle low while stopped");

    for (int p = 0; p <= 5; p++)
      for (int du = 0; du <= 6; du++)
        for (int pol = 0; pol < 2; pol++) begin
          string tg;
          tg = (p == 0) ? "R11 period zero" :
               (du == 0) ? "R5 duty zero" :
               (du >= p) ? "R5 duty at or above period" : "R4 R5 sweep";
          cyc(1, 4'hC, pol ? 32'h0 : 32'h10, "R6 stop");
          cyc(1, 4'h4, 32'(p), "R6 stopped period write");
          cyc(1, 4'h8, 32'(du), "R6 stopped duty write");
          cyc(1, 4'hC, pol ? 32'h0B : 32'h13, "R7 start");
          idle(2 * p + 3, tg);
        end

    cyc(1, 4'hC, 32'h0, "R6 stop");
    cyc(1, 4'h4, 8, "R7 setup");
    cyc(1, 4'h8, 2, "R7 setup");
    cyc(1, 4'hC, 32'h0B, "R7 start");
    idle(3, "R8 before change");
    cyc(1, 4'h4, 4, "R8 mid-period period write");
    cyc(1, 4'h8, 3, "R8 mid-period duty write");
    idle(10, "R8 after change");
    cyc(1, 4'hC, 32'h13, "R8 polarity write");
    idle(10, "R8 polarity at boundary");

    cyc(1, 4'hC, 32'h4B, "R9 lock");
    cyc(1, 4'h4, 3, "R9 locked period write");
    cyc(1, 4'h8, 1, "R9 locked duty write");
    rd(4'h4, 3, "R9 period captured");
    rd(4'h8, 1, "R9 duty captured");
    idle(20, "R9 waveform held");
    cyc(1, 4'hC, 32'h13, "R10 unlock with polarity");
    idle(12, "R10 atomic switch");

    cyc(1, 4'hC, 32'h10, "R6 stop running");
    idle(4, "R6 stopped after run");
    summary();
  end
endmodule